// File: doc/BRIEF.md
# Linked-List Descriptor Prefetcher with Write-Back

This block walks a chain of DMA descriptors kept in memory and feeds them to a downstream dispatcher. After a rising edge on `run`, it reads a whole 8-word descriptor image in one beat from the read port, starting at `start_ptr`. If the ownership flag in the control word is set, it offers the image to the dispatcher through a valid/ready push port. It then follows the next-descriptor pointer in the image. If it finds a descriptor whose flag is clear, it stops fetching. It treats that as the end of the list, or as a list that software has not finished yet.

Each forwarded descriptor leaves its address (and its control word) in a pending queue. The queue is as deep as the dispatcher's own descriptor buffer, so fetching pauses while it is full. The dispatcher returns one completion response per descriptor, in order. Each response pops the oldest pending entry, and the block writes three words into that descriptor's memory image: the transferred byte count, the status, and the control word with its ownership flag cleared.

Descriptor word layout (32-bit words, byte offset = 4 × index): 0 source address, 1 destination address, 2 length, 3 next-descriptor pointer, 4 bytes actually moved, 5 status, 6 unused, 7 control. Word i occupies bits [32i+31:32i] of the 256-bit image. Descriptor addresses are 32-byte aligned.

Top module: `desc_prefetch`

## Requirements
- R1: A rising edge on `run` makes the first read request use `start_ptr`. Each later read request uses word 3 of the previously fetched descriptor.
- R2: A fetched descriptor whose control word (word 7) has bit 31 set is presented unchanged on `dsp_desc`. `dsp_valid` and `dsp_desc` are held until `dsp_ready`.
- R3: A fetched descriptor whose control bit 31 is clear is not forwarded, and no further read request is issued until `run` rises again.
- R4: No read request is issued while DEPTH forwarded descriptors are still awaiting their response.
- R5: Each accepted response is applied to the oldest forwarded descriptor that has not yet received a response.
- R6: For each accepted response, three writes follow in this order: `rsp_bytes` to descriptor address + 16, `rsp_status` to + 20, then the fetched control word with bit 31 cleared to + 28.
- R7: `rsp_ready` is low whenever no forwarded descriptor is awaiting a response, and while a write-back is in progress.
- R8: `idle` is high after reset and once fetching has stopped with no pending descriptor and no write-back in progress. It is low in the cycle after `run` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Rising edge starts traversal; low before a request cancels fetching |
| start_ptr | input | ADDR_W | Address of the first descriptor |
| idle | output | 1 | Stopped, nothing pending, no write-back |
| rd_req_valid | output | 1 | Descriptor read request |
| rd_req_ready | input | 1 | Read request accepted |
| rd_addr | output | ADDR_W | Descriptor address to read |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 256 | Whole descriptor image |
| dsp_valid | output | 1 | Descriptor offered to dispatcher |
| dsp_ready | input | 1 | Dispatcher accepts descriptor |
| dsp_desc | output | 256 | Forwarded descriptor image |
| rsp_valid | input | 1 | Completion response from dispatcher |
| rsp_ready | output | 1 | Response accepted |
| rsp_bytes | input | 32 | Bytes actually moved |
| rsp_status | input | 32 | Completion status |
| wr_valid | output | 1 | Write-back request |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | ADDR_W | Write-back byte address |
| wr_data | output | 32 | Write-back word |

## Verification
`idle` falls one rising edge after `run` is seen high. The read request is up in the same cycle, and a forwarded descriptor appears the cycle after its read data is accepted. The first write-back word is offered the cycle after a response handshake, and each following word the cycle after the previous write is accepted. The bench drives its inputs at the falling edge and samples 1 ns later. A valid/ready pair seen high there is logged as a transfer at the next rising edge, so every expected value is compared against the handshake in the exact cycle it happens. Read latency, ready signals and response timing are randomised from a fixed seed. Directed cases cover a list whose head is not owned and a held-off dispatcher that fills the pending queue.

// File: rtl/dpf_pkg.sv
package dpf_pkg;
    localparam int WORD_W     = 32;
    localparam int DESC_WORDS = 8;
    localparam int DESC_W     = WORD_W * DESC_WORDS;
    localparam int NEXT_IDX   = 3;
    localparam int BYTES_IDX  = 4;
    localparam int STAT_IDX   = 5;
    localparam int CTRL_IDX   = 7;
    localparam int OWN_BIT    = 31;

    typedef enum logic [2:0] {F_IDLE, F_REQ, F_WAIT, F_PUSH, F_STOP} fetch_st_e;
    typedef enum logic [1:0] {W_IDLE, W_BYTES, W_STAT, W_CTRL} wb_st_e;
endpackage

// File: rtl/dpf_pend_fifo.sv
module dpf_pend_fifo #(
    parameter int W     = 64,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic [W-1:0] store_q [DEPTH];

    assign full  = (q.cnt == FULL_CNT);
    assign empty = (q.cnt == '0);
    assign head  = store_q[q.rp];

    always_comb begin
        d = q;
        if (push) d.wp = (q.wp == LAST) ? '0 : q.wp + 1'b1;
        if (pop)  d.rp = (q.rp == LAST) ? '0 : q.rp + 1'b1;
        case ({push, pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
        if (push) store_q[q.wp] <= push_data;
    end

    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop));
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/dpf_fetch.sv
module dpf_fetch
    import dpf_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [ADDR_W-1:0] start_ptr,
    input  logic              pend_full,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_rsp_valid,
    input  logic [DESC_W-1:0] rd_rsp_data,
    output logic              dsp_valid,
    input  logic              dsp_ready,
    output logic [DESC_W-1:0] dsp_desc,
    output logic              push,
    output logic [ADDR_W-1:0] push_addr,
    output logic [WORD_W-1:0] push_ctrl,
    output logic              stopped
);
    typedef struct packed {
        fetch_st_e         st;
        logic              run;
        logic [ADDR_W-1:0] ptr;
        logic [DESC_W-1:0] desc;
    } fetch_t;

    fetch_t q, d;

    assign rd_addr   = q.ptr;
    assign dsp_desc  = q.desc;
    assign push_addr = q.ptr;
    assign push_ctrl = q.desc[CTRL_IDX*WORD_W +: WORD_W];
    assign stopped   = (q.st == F_IDLE) || (q.st == F_STOP);

    always_comb begin
        d            = q;
        d.run        = run;
        rd_req_valid = 1'b0;
        dsp_valid    = 1'b0;
        push         = 1'b0;
        case (q.st)
            F_IDLE, F_STOP: begin
                if (run && !q.run) begin
                    d.ptr = start_ptr;
                    d.st  = F_REQ;
                end
            end
            F_REQ: begin
                if (!run) begin
                    d.st = F_IDLE;
                end else if (!pend_full) begin
                    rd_req_valid = 1'b1;
                    if (rd_req_ready) d.st = F_WAIT;
                end
            end
            F_WAIT: begin
                if (rd_rsp_valid) begin
                    d.desc = rd_rsp_data;
                    d.st   = rd_rsp_data[CTRL_IDX*WORD_W + OWN_BIT] ? F_PUSH : F_STOP;
                end
            end
            F_PUSH: begin
                dsp_valid = 1'b1;
                if (dsp_ready) begin
                    push  = 1'b1;
                    d.ptr = q.desc[NEXT_IDX*WORD_W +: ADDR_W];
                    d.st  = F_REQ;
                end
            end
            default: d.st = F_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st   <= F_IDLE;
            q.run  <= 1'b0;
            q.ptr  <= '0;
            q.desc <= '0;
        end else begin
            q <= d;
        end
    end

    a_r2_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_valid && !dsp_ready |=> dsp_valid && $stable(dsp_desc));
    a_r3_only_owned: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_valid |-> push_ctrl[OWN_BIT]);
endmodule

// File: rtl/dpf_writeback.sv
module dpf_writeback
    import dpf_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pend_valid,
    input  logic [ADDR_W-1:0] pend_addr,
    input  logic [WORD_W-1:0] pend_ctrl,
    output logic              pop,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic [WORD_W-1:0] rsp_bytes,
    input  logic [WORD_W-1:0] rsp_status,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              busy
);
    localparam logic [ADDR_W-1:0] OFF_BYTES = ADDR_W'(BYTES_IDX * 4);
    localparam logic [ADDR_W-1:0] OFF_STAT  = ADDR_W'(STAT_IDX * 4);
    localparam logic [ADDR_W-1:0] OFF_CTRL  = ADDR_W'(CTRL_IDX * 4);
    localparam logic [WORD_W-1:0] OWN_MASK  = WORD_W'(1) << OWN_BIT;

    typedef struct packed {
        wb_st_e            st;
        logic [ADDR_W-1:0] base;
        logic [WORD_W-1:0] bytes;
        logic [WORD_W-1:0] stat;
        logic [WORD_W-1:0] ctrl;
    } wb_t;

    wb_t q, d;

    assign busy = (q.st != W_IDLE);

    always_comb begin
        d         = q;
        pop       = 1'b0;
        rsp_ready = 1'b0;
        wr_valid  = 1'b0;
        wr_addr   = q.base;
        wr_data   = '0;
        case (q.st)
            W_IDLE: begin
                rsp_ready = pend_valid;
                if (rsp_valid && pend_valid) begin
                    pop     = 1'b1;
                    d.base  = pend_addr;
                    d.ctrl  = pend_ctrl & ~OWN_MASK;
                    d.bytes = rsp_bytes;
                    d.stat  = rsp_status;
                    d.st    = W_BYTES;
                end
            end
            W_BYTES: begin
                wr_valid = 1'b1;
                wr_addr  = q.base + OFF_BYTES;
                wr_data  = q.bytes;
                if (wr_ready) d.st = W_STAT;
            end
            W_STAT: begin
                wr_valid = 1'b1;
                wr_addr  = q.base + OFF_STAT;
                wr_data  = q.stat;
                if (wr_ready) d.st = W_CTRL;
            end
            W_CTRL: begin
                wr_valid = 1'b1;
                wr_addr  = q.base + OFF_CTRL;
                wr_data  = q.ctrl;
                if (wr_ready) d.st = W_IDLE;
            end
            default: d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st    <= W_IDLE;
            q.base  <= '0;
            q.bytes <= '0;
            q.stat  <= '0;
            q.ctrl  <= '0;
        end else begin
            q <= d;
        end
    end

    a_r6_own_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && (wr_addr == q.base + OFF_CTRL) |-> !wr_data[OWN_BIT]);
    a_r6_write_held: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
    a_r7_no_rsp_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !rsp_ready);
endmodule

// File: rtl/desc_prefetch.sv
module desc_prefetch
    import dpf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [ADDR_W-1:0] start_ptr,
    output logic              idle,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_rsp_valid,
    input  logic [255:0]      rd_rsp_data,
    output logic              dsp_valid,
    input  logic              dsp_ready,
    output logic [255:0]      dsp_desc,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic [31:0]       rsp_bytes,
    input  logic [31:0]       rsp_status,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [31:0]       wr_data
);
    localparam int ENTRY_W = ADDR_W + WORD_W;

    logic              push, pop, pend_full, pend_empty, stopped, wb_busy;
    logic [ADDR_W-1:0] push_addr;
    logic [WORD_W-1:0] push_ctrl;
    logic [ENTRY_W-1:0] pend_head;

    dpf_fetch #(.ADDR_W(ADDR_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .run(run), .start_ptr(start_ptr),
        .pend_full(pend_full),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .dsp_valid(dsp_valid), .dsp_ready(dsp_ready), .dsp_desc(dsp_desc),
        .push(push), .push_addr(push_addr), .push_ctrl(push_ctrl), .stopped(stopped)
    );

    dpf_pend_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_pend (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_data({push_addr, push_ctrl}),
        .pop(pop), .head(pend_head), .full(pend_full), .empty(pend_empty)
    );

    dpf_writeback #(.ADDR_W(ADDR_W)) u_wb (
        .clk(clk), .rst_n(rst_n),
        .pend_valid(!pend_empty),
        .pend_addr(pend_head[ENTRY_W-1 -: ADDR_W]),
        .pend_ctrl(pend_head[WORD_W-1:0]),
        .pop(pop),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_bytes(rsp_bytes), .rsp_status(rsp_status),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(wb_busy)
    );

    assign idle = stopped && pend_empty && !wb_busy;

    a_r4_no_fetch_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> !pend_full);
    a_r7_rsp_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |-> !pend_empty);
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !rd_req_valid && !dsp_valid && !wr_valid && !rsp_ready);
endmodule

// File: tb/desc_prefetch_tb.sv
`timescale 1ns/1ps
module desc_prefetch_tb;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic         rst_n, run, idle;
    logic [31:0]  start_ptr, rd_addr, wr_addr, wr_data, rsp_bytes, rsp_status;
    logic         rd_req_valid, rd_req_ready, rd_rsp_valid;
    logic [255:0] rd_rsp_data, dsp_desc;
    logic         dsp_valid, dsp_ready, rsp_valid, rsp_ready, wr_valid, wr_ready;

    desc_prefetch #(.ADDR_W(32), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .run(run), .start_ptr(start_ptr), .idle(idle),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .dsp_valid(dsp_valid), .dsp_ready(dsp_ready), .dsp_desc(dsp_desc),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_bytes(rsp_bytes), .rsp_status(rsp_status),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    logic [31:0] mem [256];
    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    int chain_addr [33];
    int fetch_idx, fwd_idx;
    logic [31:0] out_addr [$];
    logic [31:0] out_ctrl [$];
    logic [31:0] ew_addr [$];
    logic [31:0] ew_data [$];
    bit rsp_hold, dsp_all, rd_pend;
    logic [31:0] rd_pend_addr;
    int rd_lat;

    task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [255:0] image(input logic [31:0] a);
        logic [255:0] img;
        for (int i = 0; i < 8; i++) img[i*32 +: 32] = mem[(a >> 2) + i];
        return img;
    endfunction

    // n owned descriptors followed by one unowned terminator, scattered over 32-byte slots
    task automatic build(input int n, input int off);
        for (int k = 0; k <= n; k++) chain_addr[k] = ((k * 7 + off) % 32) * 32;
        for (int k = 0; k <= n; k++) begin
            int b = chain_addr[k] >> 2;
            mem[b+0] = 32'h1000_0000 + k;
            mem[b+1] = 32'h2000_0000 + k;
            mem[b+2] = $urandom;
            mem[b+3] = (k < n) ? chain_addr[k+1] : 32'h0;
            mem[b+4] = 32'h0;
            mem[b+5] = 32'h0;
            mem[b+6] = $urandom;
            mem[b+7] = {(k < n), 31'($urandom)};
        end
    endtask

    // environment: memory, dispatcher and write sink, driven at the falling edge
    initial begin
        rd_rsp_valid = 0; rd_rsp_data = '0; rd_req_ready = 0; dsp_ready = 0;
        wr_ready = 0; rsp_valid = 0; rsp_bytes = 0; rsp_status = 0; rd_pend = 0; rd_lat = 0;
        forever begin
            @(negedge clk);
            rd_rsp_valid = 0;
            if (rd_pend) begin
                if (rd_lat == 0) begin
                    rd_rsp_valid = 1; rd_rsp_data = image(rd_pend_addr); rd_pend = 0;
                end else rd_lat--;
            end
            rd_req_ready = ($urandom % 4) != 0;
            dsp_ready    = dsp_all ? 1'b1 : (($urandom % 3) != 0);
            wr_ready     = ($urandom % 4) != 0;
            if (out_addr.size() > 0 && !rsp_hold && ($urandom % 3) == 0) begin
                rsp_valid = 1; rsp_bytes = $urandom; rsp_status = $urandom;
            end else rsp_valid = 0;
            #1;
            if (rst_n) begin
                if (out_addr.size() == DEPTH) chk(!rd_req_valid, "R4 request while queue full", rd_req_valid, 0);
                if (out_addr.size() == 0)     chk(!rsp_ready, "R7 ready with nothing pending", rsp_ready, 0);
                if (ew_addr.size() > 0)       chk(!rsp_ready, "R7 ready during write-back", rsp_ready, 0);
                if (rd_req_valid && rd_req_ready) begin
                    chk(rd_addr == chain_addr[fetch_idx], "R1 fetch address", rd_addr, chain_addr[fetch_idx]);
                    rd_pend = 1; rd_pend_addr = rd_addr; rd_lat = $urandom % 3; fetch_idx++;
                end
                if (dsp_valid && dsp_ready) begin
                    chk(dsp_desc == image(chain_addr[fwd_idx]), "R2 forwarded image", dsp_desc, image(chain_addr[fwd_idx]));
                    out_addr.push_back(chain_addr[fwd_idx]);
                    out_ctrl.push_back(mem[(chain_addr[fwd_idx] >> 2) + 7]);
                    fwd_idx++;
                end
                if (rsp_valid && rsp_ready) begin
                    logic [31:0] a, c;
                    a = out_addr.pop_front(); c = out_ctrl.pop_front();
                    ew_addr.push_back(a + 16); ew_data.push_back(rsp_bytes);
                    ew_addr.push_back(a + 20); ew_data.push_back(rsp_status);
                    ew_addr.push_back(a + 28); ew_data.push_back(c & 32'h7fff_ffff);
                end
                if (wr_valid && wr_ready) begin
                    if (ew_addr.size() == 0) chk(0, "R6 unexpected write", wr_addr, 0);
                    else begin
                        chk(wr_addr == ew_addr[0], "R5 write-back address", wr_addr, ew_addr[0]);
                        chk(wr_data == ew_data[0], "R6 write-back data", wr_data, ew_data[0]);
                        void'(ew_addr.pop_front()); void'(ew_data.pop_front());
                    end
                    mem[wr_addr >> 2] = wr_data;
                end
            end
        end
    end

    task automatic run_list(input int n, input int off, input bit hold);
        int t;
        build(n, off);
        fetch_idx = 0; fwd_idx = 0;
        rsp_hold = hold; dsp_all = hold;
        @(negedge clk); start_ptr = chain_addr[0]; run = 1;
        @(negedge clk); #2;
        chk(!idle, "R8 idle low after run rise", idle, 0);
        if (hold) begin
            repeat (80) @(negedge clk);
            #2;
            chk(fwd_idx == DEPTH, "R4 forwarded count while held", fwd_idx, DEPTH);
            chk(!idle, "R8 not idle with pending", idle, 0);
            rsp_hold = 0; dsp_all = 0;
        end
        t = 0;
        do begin
            @(negedge clk); #2; t++;
        end while (!(idle && fwd_idx == n && out_addr.size() == 0 && ew_addr.size() == 0) && t < 5000);
        chk(fwd_idx == n, "R3 forwarded count", fwd_idx, n);
        chk(fetch_idx == n + 1, "R3 fetch count", fetch_idx, n + 1);
        chk(idle, "R8 idle after list end", idle, 1);
        for (int k = 0; k < n; k++)
            chk(mem[(chain_addr[k] >> 2) + 7][31] == 1'b0, "R6 ownership cleared in memory",
                mem[(chain_addr[k] >> 2) + 7], 0);
        repeat (5) @(negedge clk);
        #2;
        chk(fetch_idx == n + 1, "R3 no fetch after stop", fetch_idx, n + 1);
        run = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5171));
        for (int i = 0; i < 256; i++) mem[i] = '0;
        rst_n = 0; run = 0; start_ptr = 0; rsp_hold = 0; dsp_all = 0;
        fetch_idx = 0; fwd_idx = 0; chain_addr[0] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #2;
        chk(idle, "R8 idle after reset", idle, 1);
        chk(!rd_req_valid && !dsp_valid && !wr_valid, "R8 outputs quiet after reset",
            {rd_req_valid, dsp_valid, wr_valid}, 0);
        chk(!rsp_ready, "R7 no ready after reset", rsp_ready, 0);

        run_list(10, 3, 0);          // R1 R2 R5 R6 main traversal
        run_list(8, 5, 1);           // R4 held dispatcher fills queue
        run_list(0, 11, 0);          // R3 head not owned
        for (int r = 0; r < 5; r++) run_list(1 + $urandom % 12, $urandom % 32, 0);
        run_list(DEPTH, 0, 1);       // R4 exactly DEPTH descriptors

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule